// File: doc/BRIEF.md
# Serial Memory Bus Type Prober

This block works out which kind of serial-memory bus a board carries. On a request it walks a short, prioritised list of candidate device addresses. For each candidate it first asks a lower-level bit engine to recover the bus. It then sends a START with the candidate address in read mode. The first candidate that acknowledges selects the bus type. Before the STOP, the block completes the access with one read byte whose value it discards. The selected table index plus one is kept as the stored type code, where zero means unknown. While a code is held, later requests return at once without touching the bus. An invalidate input forgets the code.

The block drives the bit engine through a command stream and takes a response back. The command interface is valid/ready. The block raises `cmd_valid` with an opcode and byte and holds all three steady until `cmd_ready` is seen high at a clock edge. Only one command is ever in flight. The engine answers it with a one-cycle `rsp_valid` pulse carrying `rsp_ok`. Responses have no back-pressure. The engine may keep `cmd_ready` low for as long as it needs. The request side uses plain control pins: `req` in, a one-cycle `done` out, and `found`, `type_code` and the selected entry's memory and sensor addresses held as status.

Top module: `i2c_chain_prober`

## Requirements
- R1: After reset `done`, `found` and `cmd_valid` are 0, `type_code` is 0, and `mem_addr` and `sense_addr` read 0xFF.
- R2: Candidates are probed in table order: slot 0 (0xA4), slot 1 (0xA0), slot 2 (0xA2). The first candidate whose START is acknowledged ends the search with `found`=1 and `type_code` = slot+1.
- R3: Every probe starts with a RECOVER command (opcode 0). If the response has `rsp_ok`=0, the block issues no START for that candidate and moves to the next one.
- R4: A START command (opcode 1) carries the candidate address with bit 0 forced to 1 (read direction).
- R5: An acknowledged START is followed by exactly one READ (opcode 2) and then one STOP (opcode 3), before `done`. STOP is never issued other than straight after a READ.
- R6: When slot 0 is selected, one further RECOVER is issued after the STOP. Its `rsp_ok` has no effect on the result.
- R7: A slot whose probe address is 0xFF ends the list. If no candidate acknowledges, the result is `found`=0 and `type_code` keeps the value 0.
- R8: When `type_code` is nonzero, a request yields `done` and `found`=1 in the next cycle and issues no command.
- R9: `inval` sets `type_code` to 0 at the next edge. The next request then probes again.
- R10: `done` is a single-cycle pulse, exactly one per accepted request. A `req` that arrives while a probe is running is ignored.
- R11: `cmd_valid`, `cmd_op` and `cmd_byte` stay stable until accepted, and no new command is issued until the previous one has been answered.
- R12: `mem_addr` and `sense_addr` show the entry selected by `type_code`: 0xFF/0xFF for slot 0, 0xA0/0x98 for slot 1, 0xA2/0x98 for slot 2, and 0xFF for both when the code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request a bus type lookup |
| inval | input | 1 | Forget the stored type code |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Result of the last completed request |
| type_code | output | 3 | Stored type: slot index plus one, 0 = unknown |
| mem_addr | output | 8 | Memory device address of the selected entry |
| sense_addr | output | 8 | Sensor device address of the selected entry |
| cmd_valid | output | 1 | Command to bit engine is valid |
| cmd_ready | input | 1 | Bit engine accepts the command |
| cmd_op | output | 2 | 0 recover, 1 start+byte, 2 read byte, 3 stop |
| cmd_byte | output | 8 | Byte sent with a start command |
| rsp_valid | input | 1 | One-cycle response to the outstanding command |
| rsp_ok | input | 1 | Recovery succeeded or address acknowledged |

## Verification
The assertions assume a bit engine that pulses `rsp_valid` only for a command it has already accepted, and only once per command. Without that, the STOP-after-READ ordering and the stability checks on `type_code` have no meaning. The bench engine keeps at most one command pending and answers a fixed two cycles after acceptance. It drops `cmd_ready` on alternate cycles so that holding under back-pressure is exercised. It acknowledges a START only when bit 0 is set and the address belongs to a fitted device. Every combination of fitted devices and failed recoveries is swept.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

  typedef enum logic [1:0] {
    OP_RECOVER = 2'd0,
    OP_START   = 2'd1,
    OP_READ    = 2'd2,
    OP_STOP    = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_RECOV,
    ST_START,
    ST_READ,
    ST_STOP,
    ST_TAIL
  } seq_state_e;

  localparam logic [7:0] NO_DEV = 8'hFF;

endpackage

// File: rtl/chain_table.sv
module chain_table #(
  parameter int          N_SLOTS     = 4,
  parameter logic [31:0] PROBE_ADDRS = 32'hFF_A2_A0_A4,
  parameter logic [31:0] MEM_ADDRS   = 32'hFF_A2_A0_FF,
  parameter logic [31:0] SENSE_ADDRS = 32'hFF_98_98_FF,
  localparam int IW = $clog2(N_SLOTS + 1),
  localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic [IW-1:0] idx,
  input  logic [IW-1:0] code,
  output logic [7:0]    probe_addr,
  output logic          is_end,
  output logic [7:0]    mem_addr,
  output logic [7:0]    sense_addr
);
  import i2cp_pkg::*;

  logic [7:0] probe_a [N_SLOTS];
  logic [7:0] mem_a   [N_SLOTS];
  logic [7:0] sense_a [N_SLOTS];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_ent
    assign probe_a[g] = PROBE_ADDRS[8*g +: 8];
    assign mem_a[g]   = MEM_ADDRS[8*g +: 8];
    assign sense_a[g] = SENSE_ADDRS[8*g +: 8];
  end

  logic [SW-1:0] psel, csel;
  logic [IW-1:0] code_m1;
  assign code_m1 = code - 1'b1;
  assign psel    = idx[SW-1:0];
  assign csel    = code_m1[SW-1:0];

  always_comb begin
    if (idx < IW'(N_SLOTS)) probe_addr = probe_a[psel];
    else                    probe_addr = NO_DEV;
    is_end = (probe_addr == NO_DEV);
  end

  always_comb begin
    if (code != '0 && code <= IW'(N_SLOTS)) begin
      mem_addr   = mem_a[csel];
      sense_addr = sense_a[csel];
    end else begin
      mem_addr   = NO_DEV;
      sense_addr = NO_DEV;
    end
  end

endmodule

// File: rtl/type_store.sv
module type_store #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_code,
  input  logic          clr,
  output logic [CW-1:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n)     code <= '0;
    else if (wr_en) code <= wr_code;
    else if (clr)   code <= '0;
  end
endmodule

// File: rtl/cmd_issuer.sv
module cmd_issuer (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  i2cp_pkg::bus_op_e   go_op,
  input  logic [7:0]          go_byte,
  output logic                outstanding,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output i2cp_pkg::bus_op_e   cmd_op,
  output logic [7:0]          cmd_byte,
  input  logic                rsp_valid,
  input  logic                rsp_ok,
  output logic                fin,
  output logic                fin_ok
);
  import i2cp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_op      <= OP_RECOVER;
      cmd_byte    <= '0;
      outstanding <= 1'b0;
    end else begin
      if (go && !outstanding) begin
        cmd_valid   <= 1'b1;
        cmd_op      <= go_op;
        cmd_byte    <= go_byte;
        outstanding <= 1'b1;
      end else begin
        if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
        if (rsp_valid && !cmd_valid) outstanding <= 1'b0;
      end
    end
  end

  assign fin    = rsp_valid && outstanding && !cmd_valid;
  assign fin_ok = rsp_ok;

endmodule

// File: rtl/i2c_chain_prober.sv
module i2c_chain_prober #(
  parameter int          N_SLOTS     = 4,
  parameter logic [31:0] PROBE_ADDRS = 32'hFF_A2_A0_A4,
  parameter logic [31:0] MEM_ADDRS   = 32'hFF_A2_A0_FF,
  parameter logic [31:0] SENSE_ADDRS = 32'hFF_98_98_FF,
  localparam int CW = $clog2(N_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          inval,
  output logic          done,
  output logic          found,
  output logic [CW-1:0] type_code,
  output logic [7:0]    mem_addr,
  output logic [7:0]    sense_addr,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_byte,
  input  logic          rsp_valid,
  input  logic          rsp_ok
);
  import i2cp_pkg::*;

  seq_state_e    state;
  logic [CW-1:0] idx;
  logic [7:0]    probe_addr;
  logic          is_end;
  logic          outstanding, fin, fin_ok;
  logic          go;
  bus_op_e       go_op, issued_op;
  logic [7:0]    go_byte;
  logic          st_wr;

  chain_table #(
    .N_SLOTS(N_SLOTS), .PROBE_ADDRS(PROBE_ADDRS),
    .MEM_ADDRS(MEM_ADDRS), .SENSE_ADDRS(SENSE_ADDRS)
  ) u_table (
    .idx(idx), .code(type_code), .probe_addr(probe_addr),
    .is_end(is_end), .mem_addr(mem_addr), .sense_addr(sense_addr)
  );

  type_store #(.CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr),
    .wr_code(idx + 1'b1), .clr(inval), .code(type_code)
  );

  cmd_issuer u_issue (
    .clk(clk), .rst_n(rst_n), .go(go), .go_op(go_op), .go_byte(go_byte),
    .outstanding(outstanding), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(issued_op), .cmd_byte(cmd_byte), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .fin(fin), .fin_ok(fin_ok)
  );

  assign cmd_op = issued_op;

  always_comb begin
    go      = 1'b0;
    go_op   = OP_RECOVER;
    go_byte = 8'h00;
    unique case (state)
      ST_RECOV, ST_TAIL: go_op = OP_RECOVER;
      ST_START: begin
        go_op   = OP_START;
        go_byte = probe_addr | 8'h01;
      end
      ST_READ: go_op = OP_READ;
      ST_STOP: go_op = OP_STOP;
      default: go_op = OP_RECOVER;
    endcase
    if (state inside {ST_RECOV, ST_START, ST_READ, ST_STOP, ST_TAIL})
      go = !outstanding;
  end

  assign st_wr = fin && ((state == ST_STOP && idx != '0) || state == ST_TAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
      found <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (req) begin
          if (type_code != '0) begin
            done  <= 1'b1;
            found <= 1'b1;
          end else begin
            idx   <= '0;
            state <= ST_SELECT;
          end
        end
        ST_SELECT: begin
          if (is_end) begin
            done  <= 1'b1;
            found <= 1'b0;
            state <= ST_IDLE;
          end else begin
            state <= ST_RECOV;
          end
        end
        ST_RECOV: if (fin) begin
          if (fin_ok) state <= ST_START;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_SELECT;
          end
        end
        ST_START: if (fin) begin
          if (fin_ok) state <= ST_READ;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_SELECT;
          end
        end
        ST_READ: if (fin) state <= ST_STOP;
        ST_STOP: if (fin) begin
          if (idx == '0) state <= ST_TAIL;
          else begin
            done  <= 1'b1;
            found <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_TAIL: if (fin) begin
          done  <= 1'b1;
          found <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chain_probe_chk.sv
module chain_probe_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inval,
  input logic          done,
  input logic          found,
  input logic [CW-1:0] type_code,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_byte
);
  logic [1:0] last_op;
  always_ff @(posedge clk) begin
    if (!rst_n) last_op <= 2'd0;
    else if (cmd_valid && cmd_ready) last_op <= cmd_op;
  end

  // R4
  start_read_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1) |-> cmd_byte[0]);

  // R5
  stop_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd3) |-> (last_op == 2'd2));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  // R2
  found_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (type_code != '0));

  // R9
  code_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(type_code) |-> (done || $past(inval)));

endmodule

bind i2c_chain_prober chain_probe_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inval(inval), .done(done), .found(found),
  .type_code(type_code), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_byte(cmd_byte)
);

// File: tb/i2c_chain_prober_test.sv
module i2c_chain_prober_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req, inval;
  logic done, found;
  logic [2:0] type_code;
  logic [7:0] mem_addr, sense_addr, cmd_byte;
  logic cmd_valid, cmd_ready, rsp_valid, rsp_ok;
  logic [1:0] cmd_op;

  i2c_chain_prober uut (
    .clk(clk), .rst_n(rst_n), .req(req), .inval(inval), .done(done),
    .found(found), .type_code(type_code), .mem_addr(mem_addr),
    .sense_addr(sense_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
  );

  int vectors = 0, errors = 0;

  // bench bit-engine model
  logic [2:0] present;
  logic [7:0] rfail;
  logic       clr;
  logic       pend, phase, res;
  int         wait_c, rec_n, log_n, done_n;
  logic [1:0] log_op [32];
  logic [7:0] log_byte [32];

  assign cmd_ready = !pend && phase;

  function automatic logic acks(input logic [7:0] b);
    if (!b[0]) return 1'b0;
    case (b)
      8'hA5: return present[0];
      8'hA1: return present[1];
      8'hA3: return present[2];
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      pend <= 1'b0; phase <= 1'b0; rsp_valid <= 1'b0; rsp_ok <= 1'b0;
      wait_c <= 0; rec_n <= 0; log_n <= 0; done_n <= 0; res <= 1'b0;
    end else begin
      phase     <= ~phase;
      rsp_valid <= 1'b0;
      if (done) done_n <= done_n + 1;
      if (cmd_valid && cmd_ready) begin
        pend   <= 1'b1;
        wait_c <= 2;
        if (log_n < 32) begin
          log_op[log_n]   <= cmd_op;
          log_byte[log_n] <= cmd_byte;
        end
        log_n <= log_n + 1;
        case (cmd_op)
          2'd0: begin res <= (rec_n < 8) ? !rfail[rec_n] : 1'b1; rec_n <= rec_n + 1; end
          2'd1: res <= acks(cmd_byte);
          default: res <= 1'b1;
        endcase
      end else if (pend) begin
        if (wait_c == 0) begin
          rsp_valid <= 1'b1; rsp_ok <= res; pend <= 1'b0;
        end else wait_c <= wait_c - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk(1'b0, {tag, " watchdog"}, 0, 1);
  endtask

  task automatic run(input logic [2:0] pres, input logic [2:0] rf);
    logic [1:0] eop [16];
    logic [7:0] eby [16];
    int n = 0, ecode = 0, held_n;
    logic [7:0] pa [3] = '{8'hA4, 8'hA0, 8'hA2};
    logic [7:0] em, es;
    bit seq_ok;
    for (int i = 0; i < 3; i++) begin
      eop[n] = 2'd0; eby[n] = 8'h00; n++;
      if (rf[i]) continue;
      eop[n] = 2'd1; eby[n] = pa[i] | 8'h01; n++;
      if (pres[i]) begin
        eop[n] = 2'd2; eby[n] = 8'h00; n++;
        eop[n] = 2'd3; eby[n] = 8'h00; n++;
        if (i == 0) begin eop[n] = 2'd0; eby[n] = 8'h00; n++; end
        ecode = i + 1;
        break;
      end
    end
    em = (ecode == 2) ? 8'hA0 : (ecode == 3) ? 8'hA2 : 8'hFF;
    es = (ecode >= 2) ? 8'h98 : 8'hFF;

    // R9: invalidate clears the stored code
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
    chk(type_code == 3'd0, "R9 inval clears code", type_code, 0);
    present = pres; rfail = {5'd0, rf};
    clr = 1'b1; @(negedge clk); clr = 1'b0;

    req = 1'b1; @(negedge clk); req = 1'b0;
    @(negedge clk); @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0;   // R10 busy request ignored
    wait_done("R2");
    chk(found == (ecode != 0), "R2/R7 found", found, ecode != 0);
    chk(type_code == 3'(ecode), "R2/R7 type_code", type_code, ecode);
    chk(mem_addr == em && sense_addr == es, "R12 entry addrs",
        {mem_addr, sense_addr}, {em, es});
    repeat (6) @(negedge clk);
    chk(log_n == n, "R3/R5/R6 command count", log_n, n);
    seq_ok = 1'b1;
    for (int k = 0; k < n && k < log_n; k++)
      if (log_op[k] != eop[k] || log_byte[k] != eby[k]) seq_ok = 1'b0;
    chk(seq_ok, "R3/R4/R5/R6 command order", pres, rf);
    chk(done_n == 1, "R10 one done per request", done_n, 1);

    if (ecode != 0) begin
      held_n = log_n;
      req = 1'b1; @(negedge clk); req = 1'b0;
      chk(done == 1'b1 && found == 1'b1, "R8 memo done next cycle", done, 1);
      repeat (4) @(negedge clk);
      chk(log_n == held_n, "R8 memo no commands", log_n, held_n);
      chk(type_code == 3'(ecode), "R8 memo code kept", type_code, ecode);
    end
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; inval = 1'b0; clr = 1'b0;
    present = 3'b000; rfail = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!done && !found && !cmd_valid && type_code == 3'd0, "R1 reset outputs",
        {done, found, cmd_valid, type_code}, 0);
    chk(mem_addr == 8'hFF && sense_addr == 8'hFF, "R1/R12 reset addrs",
        {mem_addr, sense_addr}, 16'hFFFF);
    for (int p = 0; p < 8; p++)
      for (int r = 0; r < 8; r++)
        run(3'(p), 3'(r));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule